// File: doc/BRIEF.md
# Multi-Function Pad Mux Cell

This cell controls one external I/O pad. It routes one of eight internal peripheral slots to that pad. Each slot offers output data, an output enable and a requested pull-up and pull-down. A single 32-bit configuration word decides which slot owns the pad. The same word also sets the pad's drive code, where its pull comes from, which edges of the pad input count as events, and what the pad does while the system sleeps. Software writes the word through a one-cycle write strobe and can read it back at any time.

The pad input goes through a two-stage synchronizer. It then feeds an edge detector whose event flag stays set until software clears it. A wakeup request is raised only when that flag is set and an external wake-enable bit is also set, so detecting an edge does not by itself wake anything. While the low-power input is high and the sleep-select bit is set, the sleep fields of the word take over the pad output and its enable. The pull then comes from the word as well.

Top module: `padmux_cell`

## Requirements
- R1: Bits 2:0 of the configuration word select a slot numbered 0 to 7, and that slot's data and output enable appear on `pad_do` and `pad_oe` in the same cycle.
- R2: With bit 4 set, a 0-to-1 change of `pad_di` sets `edge_evt` at the third rising clock edge after the change is presented. With bit 5 set, a 1-to-0 change does the same. Setting both bits detects either edge. Once set, `edge_evt` stays set while bit 6 is clear.
- R3: While bit 6 is set, no edge is detected, and `edge_evt` reads 0 from the cycle after bit 6 became set.
- R4: A change on `lp_mode` takes effect on the clock edge after it is sampled. While the registered low-power state is high and bit 9 is set, `pad_do` equals bit 8 and `pad_oe` equals the inverse of bit 7. Run-mode routing returns on the clock after `lp_mode` falls.
- R5: When bit 15 is 0 and the sleep override of R4 is inactive, `pad_pu` and `pad_pd` come from the selected slot. Otherwise `pad_pu` equals bit 14 and `pad_pd` equals bit 13.
- R6: `pad_drv` carries bits 12:10 unchanged. The codes are: 0 fast 1 mA, 1 fast 2 mA, 2 fast 3 mA, 3 fast 4 mA, 4 slow 6 mA, 5 fast 6 mA, 6 slow 10 mA, 7 fast 10 mA.
- R7: Bit 3 and bits 31:16 ignore writes and always read 0. Every other bit reads back the last value written.
- R8: `wake_req` is high exactly when `edge_evt` and `wake_en` are both high.
- R9: After reset the word reads 0x00000880 (slot 0, drive code 2, edge detection off, sleep output enable inactive, sleep select off, pull select 0), and `edge_evt` is 0.
- R10: With bit 9 clear, a high `lp_mode` leaves run-mode routing and pull unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current configuration word |
| per_do | input | NUM_AF | Output data per peripheral slot |
| per_oe | input | NUM_AF | Output enable per slot |
| per_pu | input | NUM_AF | Requested pull-up per slot |
| per_pd | input | NUM_AF | Requested pull-down per slot |
| lp_mode | input | 1 | Low-power mode indication |
| pad_di | input | 1 | Asynchronous pad input |
| wake_en | input | 1 | External wake enable for this pad |
| pad_do | output | 1 | Pad output data |
| pad_oe | output | 1 | Pad output enable |
| pad_pu | output | 1 | Pull-up control |
| pad_pd | output | 1 | Pull-down control |
| pad_drv | output | 3 | Drive strength and slew code |
| edge_evt | output | 1 | Sticky edge event flag |
| wake_req | output | 1 | Wakeup request |

## Verification
Several properties are checked on every cycle: reserved bits always read zero, the wakeup request never appears without both the event flag and the wake enable, the event flag stays set until a clear, a clear empties the flag on the next cycle, the register-sourced pull applies whenever bit 15 is set, and the sleep data drives the pad during an active override. Other behaviour can only be shown by the bench's scenarios. This covers the three-edge latency from a pad change to the event and the rejection of edges of the wrong polarity. It also covers the one-cycle handover when `lp_mode` rises or falls, and slot routing under many data and configuration patterns.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

    localparam int CFG_W = 32;
    localparam int AF_W  = 3;
    localparam int SLOTS = 1 << AF_W;

    localparam logic [CFG_W-1:0] CFG_WMASK = 32'h0000_FFF7;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0880;

    typedef struct packed {
        logic [15:0]     rsvd_hi;
        logic            pull_sel;
        logic            pull_up;
        logic            pull_dn;
        logic [2:0]      drv;
        logic            slp_sel;
        logic            slp_data;
        logic            slp_oe_n;
        logic            edge_clr;
        logic            fall_en;
        logic            rise_en;
        logic            rsvd3;
        logic [AF_W-1:0] af;
    } pad_cfg_t;

    typedef struct packed {
        logic dout;
        logic oe;
        logic pu;
        logic pd;
    } pad_ctl_t;

    function automatic logic [CFG_W-1:0] cfg_filter(input logic [CFG_W-1:0] w);
        return w & CFG_WMASK;
    endfunction

endpackage

// File: rtl/padmux_cfg_reg.sv
module padmux_cfg_reg
    import padmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output pad_cfg_t         cfg
);
    logic [CFG_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= CFG_RESET;
        end else if (wr) begin
            word_q <= cfg_filter(wdata);
        end
    end

    assign cfg = pad_cfg_t'(word_q);
endmodule

// File: rtl/padmux_route.sv
module padmux_route
    import padmux_pkg::*;
#(
    parameter int NUM_AF = 8
) (
    input  pad_cfg_t          cfg,
    input  logic              lp_q,
    input  logic [NUM_AF-1:0] per_do,
    input  logic [NUM_AF-1:0] per_oe,
    input  logic [NUM_AF-1:0] per_pu,
    input  logic [NUM_AF-1:0] per_pd,
    output pad_ctl_t          ctl
);
    logic [SLOTS-1:0] do_x, oe_x, pu_x, pd_x;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_AF) begin : g_used
            assign do_x[i] = per_do[i];
            assign oe_x[i] = per_oe[i];
            assign pu_x[i] = per_pu[i];
            assign pd_x[i] = per_pd[i];
        end else begin : g_empty
            assign do_x[i] = 1'b0;
            assign oe_x[i] = 1'b0;
            assign pu_x[i] = 1'b0;
            assign pd_x[i] = 1'b0;
        end
    end

    logic sleep_ovr;
    logic pull_reg;

    always_comb begin
        sleep_ovr = lp_q & cfg.slp_sel;
        pull_reg  = sleep_ovr | cfg.pull_sel;
        if (sleep_ovr) begin
            ctl.dout = cfg.slp_data;
            ctl.oe   = ~cfg.slp_oe_n;
        end else begin
            ctl.dout = do_x[cfg.af];
            ctl.oe   = oe_x[cfg.af];
        end
        ctl.pu = pull_reg ? cfg.pull_up : pu_x[cfg.af];
        ctl.pd = pull_reg ? cfg.pull_dn : pd_x[cfg.af];
    end
endmodule

// File: rtl/padmux_edge.sv
module padmux_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic evt
);
    logic [SYNC_STAGES:0] sh_q;
    logic cur, prev, hit;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], din};
    end

    assign cur  = sh_q[SYNC_STAGES-1];
    assign prev = sh_q[SYNC_STAGES];
    assign hit  = (rise_en & cur & ~prev) | (fall_en & ~cur & prev);

    always_ff @(posedge clk) begin
        if (rst)      evt <= 1'b0;
        else if (clr) evt <= 1'b0;
        else if (hit) evt <= 1'b1;
    end
endmodule

// File: rtl/padmux_cell.sv
module padmux_cell
    import padmux_pkg::*;
#(
    parameter int NUM_AF      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [NUM_AF-1:0] per_do,
    input  logic [NUM_AF-1:0] per_oe,
    input  logic [NUM_AF-1:0] per_pu,
    input  logic [NUM_AF-1:0] per_pd,
    input  logic              lp_mode,
    input  logic              pad_di,
    input  logic              wake_en,
    output logic              pad_do,
    output logic              pad_oe,
    output logic              pad_pu,
    output logic              pad_pd,
    output logic [2:0]        pad_drv,
    output logic              edge_evt,
    output logic              wake_req
);
    pad_cfg_t cfg;
    pad_ctl_t ctl;
    logic     lp_q;

    always_ff @(posedge clk) begin
        if (rst) lp_q <= 1'b0;
        else     lp_q <= lp_mode;
    end

    padmux_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    padmux_route #(.NUM_AF(NUM_AF)) u_route (
        .cfg    (cfg),
        .lp_q   (lp_q),
        .per_do (per_do),
        .per_oe (per_oe),
        .per_pu (per_pu),
        .per_pd (per_pd),
        .ctl    (ctl)
    );

    padmux_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .din     (pad_di),
        .rise_en (cfg.rise_en),
        .fall_en (cfg.fall_en),
        .clr     (cfg.edge_clr),
        .evt     (edge_evt)
    );

    assign cfg_rdata = cfg;
    assign pad_do    = ctl.dout;
    assign pad_oe    = ctl.oe;
    assign pad_pu    = ctl.pu;
    assign pad_pd    = ctl.pd;
    assign pad_drv   = cfg.drv;
    assign wake_req  = edge_evt & wake_en;
endmodule

// File: rtl/padmux_cell_chk.sv
module padmux_cell_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_rdata,
    input logic        lp_mode,
    input logic        wake_en,
    input logic        pad_do,
    input logic        pad_pu,
    input logic        pad_pd,
    input logic        edge_evt,
    input logic        wake_req
);
    logic armed = 1'b0;

    always_ff @(posedge clk) armed <= !rst;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~32'h0000_FFF7) == 32'h0); // R7

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (wake_en && edge_evt)); // R8

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (edge_evt && !cfg_rdata[6]) |=> edge_evt); // R2

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6] |=> !edge_evt); // R3

    AST_PULL_FROM_REG: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[15] |-> (pad_pu == cfg_rdata[14] && pad_pd == cfg_rdata[13])); // R5

    AST_SLEEP_DATA: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(lp_mode) && cfg_rdata[9]) |-> (pad_do == cfg_rdata[8])); // R4
endmodule

bind padmux_cell padmux_cell_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .lp_mode   (lp_mode),
    .wake_en   (wake_en),
    .pad_do    (pad_do),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .edge_evt  (edge_evt),
    .wake_req  (wake_req)
);

// File: tb/sim_padmux_cell.sv
`timescale 1ns/1ps
module sim_padmux_cell;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  per_do = '0, per_oe = '0, per_pu = '0, per_pd = '0;
    logic        lp_mode = 1'b0, pad_di = 1'b0, wake_en = 1'b0;
    logic        pad_do, pad_oe, pad_pu, pad_pd, edge_evt, wake_req;
    logic [2:0]  pad_drv;

    int vectors = 0;
    int fails = 0;
    bit started = 0;
    bit done = 0;

    always #5 clk = ~clk;

    padmux_cell u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .per_do(per_do), .per_oe(per_oe),
        .per_pu(per_pu), .per_pd(per_pd), .lp_mode(lp_mode),
        .pad_di(pad_di), .wake_en(wake_en), .pad_do(pad_do),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_drv(pad_drv), .edge_evt(edge_evt), .wake_req(wake_req)
    );

    // behavioural reference state
    logic [31:0] m_cfg;
    bit          m_lp;
    bit          m_evt;
    bit          syncq[$];

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 32'h0000_0880;
            m_lp  = 0;
            m_evt = 0;
            syncq = '{0, 0, 0};
        end else begin
            bit s2, s3;
            s3 = syncq[0];
            s2 = syncq[1];
            if (m_cfg[6]) m_evt = 0;
            else if ((m_cfg[4] && s2 && !s3) || (m_cfg[5] && !s2 && s3)) m_evt = 1;
            syncq.push_back(pad_di);
            void'(syncq.pop_front());
            m_lp = lp_mode;
            if (cfg_wr) m_cfg = cfg_wdata & 32'h0000_FFF7;
        end
        started = 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int  af;
            bit  slp, preg;
            af   = int'(m_cfg[2:0]);
            slp  = m_lp && m_cfg[9];
            preg = slp || m_cfg[15];
            chk("R7 R9 cfg_rdata", cfg_rdata, m_cfg);
            chk("R1 R4 R10 pad_do", 32'(pad_do), 32'(slp ? m_cfg[8] : per_do[af]));
            chk("R1 R4 R10 pad_oe", 32'(pad_oe), 32'(slp ? !m_cfg[7] : per_oe[af]));
            chk("R5 pad_pu", 32'(pad_pu), 32'(preg ? m_cfg[14] : per_pu[af]));
            chk("R5 pad_pd", 32'(pad_pd), 32'(preg ? m_cfg[13] : per_pd[af]));
            chk("R6 pad_drv", 32'(pad_drv), 32'(m_cfg[12:10]));
            chk("R2 R3 edge_evt", 32'(edge_evt), 32'(m_evt));
            chk("R8 wake_req", 32'(wake_req), 32'(m_evt && wake_en));
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
            cfg_wr = 1'b0;
        end
    endtask

    task automatic wr(input logic [31:0] w);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        step();
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step();
        // R9 explicit reset-state checks
        chk("R9 reset word", cfg_rdata, 32'h0000_0880);
        chk("R9 reset event", 32'(edge_evt), 32'h0);
        // R7 reserved bits
        wr(32'hFFFF_FFFF);
        chk("R7 reserved readback", cfg_rdata, 32'h0000_FFF7);
        wr(32'h0000_0000);
        // R1 slot routing
        for (int a = 0; a < 8; a++) begin
            wr(32'(a));
            per_do = 8'(1 << a); per_oe = ~8'(1 << a);
            step();
            per_do = ~per_do; per_oe = ~per_oe; per_pu = 8'hA5; per_pd = 8'h5A;
            step();
        end
        // R5 register pull, R6 drive codes
        for (int d = 0; d < 8; d++) begin
            wr(32'h0000_8000 | 32'(d << 10) | 32'((d & 1) << 14) | 32'((d & 2) << 12));
            step();
        end
        // R2 rising edge, R8 wake gating
        wr(32'h0000_0010);
        pad_di = 1'b1; step(4);
        wake_en = 1'b1; step();
        wake_en = 1'b0;
        // R3 clear
        wr(32'h0000_0050); step(2);
        pad_di = 1'b0; step(4);
        // R2 falling only: rising should be ignored
        wr(32'h0000_0020);
        pad_di = 1'b1; step(4);
        pad_di = 1'b0; step(4);
        wr(32'h0000_0040); step();
        wr(32'h0000_0030);
        pad_di = 1'b1; step(4);
        // R4 sleep override, R10 no override
        wr(32'h0000_0303 | 32'h0000_4000);
        lp_mode = 1'b1; step(3);
        lp_mode = 1'b0; step(2);
        wr(32'h0000_0183);
        lp_mode = 1'b1; step(3);
        lp_mode = 1'b0; step(2);
        wr(32'h0000_0303);
        lp_mode = 1'b1; step(3);
        lp_mode = 1'b0; step(2);
        // mixed patterns
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 6) == 0) begin
                cfg_wr = 1'b1;
                cfg_wdata = $urandom;
            end
            per_do = 8'($urandom); per_oe = 8'($urandom);
            per_pu = 8'($urandom); per_pd = 8'($urandom);
            if (($urandom % 3) == 0) pad_di = ~pad_di;
            lp_mode = (($urandom % 4) == 0) ? ~lp_mode : lp_mode;
            wake_en = 1'($urandom);
            step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule